// File: doc/BRIEF.md
# UTOPIA Cell-Level Receive Master

This block sits on the ATM-layer side of an 8-bit UTOPIA Level 1 receive port and acts as the bus master. It watches the PHY's cell-available flag and drives the active-low receive enable. It captures complete 53-byte cells, aligned on the start-of-cell marker, and forwards every captured byte on a stream output. Each byte carries markers for the first and last byte of its cell. The port runs at half the system clock. The block models this with an internal divide-by-two enable, so every port sample and every enable change happens on alternate system clock edges.

The handshake is cell-level only. Once a start-of-cell byte has been taken, the enable stays asserted until the 53rd byte. Between cells, the enable is released or held according to three things: whether the PHY still offers a cell, whether the downstream side can take a full cell, and whether a tag-insertion wait is selected. An active-low activity LED output goes low on each new cell and is held low by a long stretch timer.

Top module: `utopia_rx_master`

## Requirements
- R1: While reset is asserted, rx_enb_n and led_n are high, and cell_valid, cell_first, cell_last and sync_err are low.
- R2: Port inputs are sampled, and rx_enb_n changes, only on sample edges. A sample edge is every second rising system clock edge, and the first one after reset release is the second rising edge.
- R3: While rx_enb_n is high and no tag wait is pending, a sample edge that sees rx_clav high and cell_ready high drives rx_enb_n low.
- R4: With rx_enb_n low, a sample with rx_soc high starts a cell. Byte index 0 is output with cell_first, and the following samples are output in order. Byte index 52 is output with cell_last. rx_enb_n stays low from the start-of-cell byte through the last byte.
- R5: Samples taken with rx_soc low while no cell is in progress produce no output byte.
- R6: A sample with rx_soc high while a cell is in progress gives a one-cycle sync_err pulse together with that byte. The byte is output as byte index 0 of a new cell, and counting restarts from it.
- R7: With tag_en low, if rx_clav and cell_ready are both high at the last-byte sample, rx_enb_n stays low. The next cell can then start on the very next sample edge.
- R8: With tag_en high, rx_enb_n goes high at the last-byte sample and stays high for exactly TAG_TICKS sample periods before it can be asserted again (TAG_TICKS at most 8).
- R9: With tag_en low and rx_clav or cell_ready low at the last-byte sample, rx_enb_n goes high. While cell_ready is low, rx_enb_n is not asserted.
- R10: led_n goes low in the cycle after each accepted start-of-cell byte and stays low for LED_TICKS sample periods. A further start-of-cell restarts the count.
- R11: Each accepted byte is output with cell_valid high for exactly one system clock cycle, and cell_data equals the rx_data value sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_en | input | 1 | Selects the tag-insertion wait between cells |
| rx_clav | input | 1 | PHY cell-available flag |
| rx_soc | input | 1 | PHY start-of-cell marker |
| rx_data | input | 8 | PHY receive byte |
| rx_enb_n | output | 1 | Active-low receive enable to the PHY |
| cell_ready | input | 1 | Downstream can accept a full cell (consulted at cell boundaries) |
| cell_valid | output | 1 | Output byte valid strobe |
| cell_data | output | 8 | Output byte |
| cell_first | output | 1 | Output byte is byte index 0 of a cell |
| cell_last | output | 1 | Output byte is byte index 52 of a cell |
| sync_err | output | 1 | Start-of-cell seen while a cell was in progress |
| led_n | output | 1 | Active-low activity LED |

## Verification
The bench builds the block with TAG_TICKS at 4 and LED_TICKS at 30. The second value is far below the full-scale stretch, so the bench can see the LED expire and can see a new cell restart it within a short run. A 4-tick tag wait gives an 8-cycle enable-high window, and the bench measures it against the value from the requirement. With these values, back-to-back cells, a truncated cell followed by a resynchronising start-of-cell, leading junk bytes and a held-off downstream side all fit into a few thousand cycles. Every output is then compared against the behavioural model on every clock.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
    localparam int unsigned CELL_BYTES = 53;
    localparam int unsigned CNT_W      = $clog2(CELL_BYTES);
    localparam int unsigned DATA_W     = 8;
    typedef logic [DATA_W-1:0] rx_byte_t;
endpackage

// File: rtl/utopia_rx_clkdiv.sv
module utopia_rx_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic tick_d, tick_q;

    always_comb begin
        tick_d = ~tick_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign tick_o = tick_q;
endmodule

// File: rtl/utopia_rx_ctrl.sv
module utopia_rx_ctrl
    import utopia_rx_pkg::*;
#(
    parameter int unsigned TAG_TICKS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_i,
    input  logic     tag_en_i,
    input  logic     clav_i,
    input  logic     soc_i,
    input  rx_byte_t data_i,
    input  logic     ready_i,
    output logic     enb_n_o,
    output logic     start_o,
    output logic     valid_o,
    output rx_byte_t data_o,
    output logic     first_o,
    output logic     last_o,
    output logic     err_o
);
    localparam int unsigned GAP_W = (TAG_TICKS > 1) ? $clog2(TAG_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_BYTES - 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(TAG_TICKS - 1);

    typedef struct packed {
        logic             enb_n;
        logic             in_cell;
        logic [CNT_W-1:0] idx;
        logic [GAP_W-1:0] gap;
        logic             vld;
        rx_byte_t         data;
        logic             first;
        logic             last;
        logic             err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  end_cell;
    logic  take;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.vld   = 1'b0;
        ctl_d.first = 1'b0;
        ctl_d.last  = 1'b0;
        ctl_d.err   = 1'b0;
        end_cell    = 1'b0;
        take        = tick_i && !ctl_q.enb_n;
        start_o     = take && soc_i;
        if (tick_i) begin
            if (!ctl_q.enb_n) begin
                if (soc_i) begin
                    ctl_d.vld     = 1'b1;
                    ctl_d.data    = data_i;
                    ctl_d.first   = 1'b1;
                    ctl_d.err     = ctl_q.in_cell;
                    ctl_d.in_cell = 1'b1;
                    ctl_d.idx     = CNT_W'(1);
                end else if (ctl_q.in_cell) begin
                    ctl_d.vld  = 1'b1;
                    ctl_d.data = data_i;
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.last    = 1'b1;
                        ctl_d.in_cell = 1'b0;
                        ctl_d.idx     = '0;
                        end_cell      = 1'b1;
                    end else begin
                        ctl_d.idx = ctl_q.idx + CNT_W'(1);
                    end
                end
                if (end_cell) begin
                    if (tag_en_i) begin
                        ctl_d.enb_n = 1'b1;
                        ctl_d.gap   = GAP_LOAD;
                    end else if (!(clav_i && ready_i)) begin
                        ctl_d.enb_n = 1'b1;
                    end
                end
            end else if (ctl_q.gap != '0) begin
                ctl_d.gap = ctl_q.gap - GAP_W'(1);
            end else if (clav_i && ready_i) begin
                ctl_d.enb_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.enb_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign enb_n_o = ctl_q.enb_n;
    assign valid_o = ctl_q.vld;
    assign data_o  = ctl_q.data;
    assign first_o = ctl_q.first;
    assign last_o  = ctl_q.last;
    assign err_o   = ctl_q.err;
endmodule

// File: rtl/utopia_rx_led.sv
module utopia_rx_led #(
    parameter int unsigned LED_TICKS = 1 << 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic led_n_o
);
    localparam int unsigned W = $clog2(LED_TICKS + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         led_n;
    } led_t;

    led_t led_d, led_q;

    always_comb begin
        led_d = led_q;
        if (restart_i) begin
            led_d.cnt = W'(LED_TICKS);
        end else if (tick_i && led_q.cnt != '0) begin
            led_d.cnt = led_q.cnt - W'(1);
        end
        led_d.led_n = (led_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q.cnt   <= '0;
            led_q.led_n <= 1'b1;
        end else begin
            led_q <= led_d;
        end
    end

    assign led_n_o = led_q.led_n;
endmodule

// File: rtl/utopia_rx_master.sv
module utopia_rx_master
    import utopia_rx_pkg::*;
#(
    parameter int unsigned TAG_TICKS = 4,
    parameter int unsigned LED_TICKS = 1 << 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tag_en,
    input  logic       rx_clav,
    input  logic       rx_soc,
    input  logic [7:0] rx_data,
    output logic       rx_enb_n,
    input  logic       cell_ready,
    output logic       cell_valid,
    output logic [7:0] cell_data,
    output logic       cell_first,
    output logic       cell_last,
    output logic       sync_err,
    output logic       led_n
);
    logic tick;
    logic start;

    utopia_rx_clkdiv u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    utopia_rx_ctrl #(
        .TAG_TICKS (TAG_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .tag_en_i (tag_en),
        .clav_i   (rx_clav),
        .soc_i    (rx_soc),
        .data_i   (rx_data),
        .ready_i  (cell_ready),
        .enb_n_o  (rx_enb_n),
        .start_o  (start),
        .valid_o  (cell_valid),
        .data_o   (cell_data),
        .first_o  (cell_first),
        .last_o   (cell_last),
        .err_o    (sync_err)
    );

    utopia_rx_led #(
        .LED_TICKS (LED_TICKS)
    ) u_led (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .restart_i (start),
        .led_n_o   (led_n)
    );
endmodule

// File: rtl/utopia_rx_master_chk.sv
module utopia_rx_master_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_enb_n,
    input logic cell_valid,
    input logic cell_first,
    input logic cell_last,
    input logic sync_err,
    input logic led_n
);
    p_enb_low_in_cell_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && !cell_last) |-> !rx_enb_n);

    p_enb_on_sample_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_enb_n) |=> $stable(rx_enb_n));

    p_valid_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |=> !cell_valid);

    p_err_with_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> (cell_valid && cell_first));

    p_led_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && cell_first) |-> !led_n);

    p_first_not_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cell_first |-> !cell_last);
endmodule

bind utopia_rx_master utopia_rx_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_enb_n   (rx_enb_n),
    .cell_valid (cell_valid),
    .cell_first (cell_first),
    .cell_last  (cell_last),
    .sync_err   (sync_err),
    .led_n      (led_n)
);

// File: tb/utopia_rx_master_tb.sv
module utopia_rx_master_tb;
    localparam int TAG = 4;
    localparam int LED = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tag_en = 1'b0;
    logic       rx_clav = 1'b0;
    logic       rx_soc = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       cell_ready = 1'b1;
    logic       rx_enb_n, cell_valid, cell_first, cell_last, sync_err, led_n;
    logic [7:0] cell_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    utopia_rx_master #(.TAG_TICKS(TAG), .LED_TICKS(LED)) u_dut (
        .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .rx_clav(rx_clav),
        .rx_soc(rx_soc), .rx_data(rx_data), .rx_enb_n(rx_enb_n),
        .cell_ready(cell_ready), .cell_valid(cell_valid), .cell_data(cell_data),
        .cell_first(cell_first), .cell_last(cell_last), .sync_err(sync_err),
        .led_n(led_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // PHY stimulus queues
    bit       q_soc[$];
    bit [7:0] q_dat[$];

    task automatic push_junk(input int n);
        for (int i = 0; i < n; i++) begin q_soc.push_back(1'b0); q_dat.push_back(8'hE0 + 8'(i)); end
        rx_clav = 1'b1;
    endtask

    task automatic push_cell(input int seed, input int len);
        for (int i = 0; i < len; i++) begin
            q_soc.push_back(i == 0);
            q_dat.push_back(8'(seed + i));
        end
        rx_clav = 1'b1;
    endtask

    // behavioural reference model
    int m_ph = 0, m_idx = -1, m_gap = 0, m_led = 0;
    int e_enb = 1, e_valid = 0, e_data = 0, e_first = 0, e_last = 0, e_err = 0, e_led = 1;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_idx = -1; m_gap = 0; m_led = 0;
            e_enb = 1; e_valid = 0; e_first = 0; e_last = 0; e_err = 0; e_led = 1;
        end else begin
            int tk, endc, reload;
            tk = m_ph; m_ph = 1 - m_ph;
            e_valid = 0; e_first = 0; e_last = 0; e_err = 0;
            endc = 0; reload = 0;
            if (tk == 1) begin
                if (e_enb == 0) begin
                    if (rx_soc) begin
                        e_err = (m_idx >= 0); e_valid = 1; e_first = 1; e_data = rx_data;
                        m_idx = 1; m_led = LED; reload = 1;
                    end else if (m_idx >= 0) begin
                        e_valid = 1; e_data = rx_data;
                        if (m_idx == 52) begin e_last = 1; m_idx = -1; endc = 1; end
                        else m_idx++;
                    end
                    if (endc == 1) begin
                        if (tag_en) begin e_enb = 1; m_gap = TAG - 1; end
                        else if (!(rx_clav && cell_ready)) e_enb = 1;
                    end
                end else if (m_gap > 0) m_gap--;
                else if (rx_clav && cell_ready) e_enb = 0;
                if (reload == 0 && m_led > 0) m_led--;
            end
            e_led = (m_led == 0);
        end
    end

    // per-cycle comparison and PHY drive at the falling edge
    int cells_seen = 0, errs_seen = 0, last_cyc = 0, spacing = -1;
    int run = 0, last_run = -1;

    always @(negedge clk) begin
        if (!done) begin
            chk("R1 R2 R3 R7 R8 R9 rx_enb_n", int'(rx_enb_n), e_enb);
            chk("R5 R11 cell_valid", int'(cell_valid), e_valid);
            if (e_valid == 1) chk("R11 cell_data", int'(cell_data), e_data);
            chk("R4 R6 cell_first", int'(cell_first), e_first);
            chk("R4 cell_last", int'(cell_last), e_last);
            chk("R6 sync_err", int'(sync_err), e_err);
            chk("R10 led_n", int'(led_n), e_led);
        end
        if (cell_valid && cell_first) spacing = cyc - last_cyc;
        if (cell_valid && cell_last) begin cells_seen++; last_cyc = cyc; end
        if (sync_err) errs_seen++;
        if (rx_enb_n) run++;
        else begin if (run > 0) last_run = run; run = 0; end
        // PHY: present next byte if the coming edge samples with enable low
        rx_soc = 1'b0;
        if (rst_n && m_ph == 1 && !rx_enb_n && q_soc.size() != 0) begin
            rx_soc = q_soc.pop_front();
            rx_data = q_dat.pop_front();
        end
        rx_clav = (q_soc.size() != 0);
    end

    task automatic wait_idle();
        while (q_soc.size() != 0 || u_dut.cell_valid) @(negedge clk);
        repeat (12) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 rx_enb_n reset", int'(rx_enb_n), 1);
        chk("R1 led_n reset", int'(led_n), 1);
        chk("R1 cell_valid reset", int'(cell_valid), 0);
        chk("R1 sync_err reset", int'(sync_err), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk); #1;

        // junk bytes then two back-to-back untagged cells
        push_junk(3);
        push_cell(8'h10, 53);
        push_cell(8'h80, 53);
        while (cells_seen < 2) @(negedge clk);
        chk("R7 back-to-back spacing", spacing, 2);
        wait_idle();
        chk("R4 R5 cells after junk", cells_seen, 2);

        // truncated cell then resynchronising start-of-cell
        push_cell(8'h40, 10);
        push_cell(8'hA0, 53);
        while (cells_seen < 3) @(negedge clk);
        wait_idle();
        chk("R6 sync_err count", errs_seen, 1);

        // tagged back-to-back cells
        tag_en = 1'b1;
        push_cell(8'h20, 53);
        push_cell(8'h60, 53);
        while (cells_seen < 5) @(negedge clk);
        chk("R8 tag gap cycles", last_run, 2 * TAG);
        wait_idle();
        tag_en = 1'b0;

        // downstream not ready
        cell_ready = 1'b0;
        push_cell(8'h30, 53);
        repeat (40) @(negedge clk);
        chk("R9 enable held off", int'(rx_enb_n), 1);
        chk("R9 no cell while not ready", cells_seen, 5);
        #1 cell_ready = 1'b1;
        while (cells_seen < 6) @(negedge clk);
        wait_idle();

        // LED expiry
        repeat (2 * LED + 10) @(negedge clk);
        chk("R10 led released", int'(led_n), 1);
        chk("R4 total cells", cells_seen, 6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule